// File: doc/BRIEF.md
# UART Control Register with Graceful Transmit Disable

This block holds the UART control word and applies its gating to a small transmit path. A bus write at byte offset 0x030 updates the control word, and a combinational read port returns it. Behind the register, an 8-entry transmit FIFO feeds an 8N1 serializer. The serializer advances one bit on each single-cycle baud tick supplied from outside. A receive gate output tells an external receiver whether it may accept characters.

The main property is a graceful disable. Software may clear the module enable or the transmit enable at any moment. The character already on the line always runs to its stop bit, and only the next launch is held back. Software polls the busy output to learn when the line has gone quiet before it reprograms the block. After reset the module is off, and both direction enables are on.

Top module: `uart_ctl_tx`

## Requirements
- R1: Reading byte offset 0x030 after reset returns 0x0000_0300. Any other read offset returns zero.
- R2: A write to offset 0x030 is visible on the read port in the next cycle. Bits 6, 12, 13 and 16 to 31 always read as zero, so the writable mask is 0x0000_CFBF.
- R3: A character launches only on a baud tick, and only when the serializer is idle, bit 0 (module enable) and bit 8 (transmit enable) are both 1, and the FIFO holds data.
- R4: A frame is a start bit of 0, then eight data bits with the LSB first, then a stop bit of 1. The line changes only after a baud tick. While idle, the line is high.
- R5: busy rises in the cycle the start bit appears and falls after the baud tick that ends the stop bit.
- R6: Clearing bit 0 or bit 8 during a frame does not cut the frame short. The frame finishes, and no further character launches.
- R7: The FIFO holds 8 bytes and sends them in push order. A push into a full FIFO is dropped, even if a pop happens in the same cycle. Such a push sets overflow, which stays 1 until reset.
- R8: While fifo_en is 0, the FIFO is emptied and pushes are discarded. The character already on the line is not affected.
- R9: While bit 7 (loopback) is 1, the serial stream appears on lb_out and tx_pin is held at 1. While bit 7 is 0, lb_out is held at 1.
- R10: rx_gate equals bit 0 AND bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Read data (combinational) |
| fifo_en | input | 1 | FIFO enable from line control; low flushes |
| push | input | 1 | Push a byte into the transmit FIFO |
| push_data | input | 8 | Byte to push |
| baud_tick | input | 1 | One-cycle bit-rate strobe |
| tx_pin | output | 1 | External serial output |
| lb_out | output | 1 | Internal loopback serial output |
| busy | output | 1 | Character in flight |
| overflow | output | 1 | Sticky FIFO overflow flag |
| rx_gate | output | 1 | Receiver permitted |

## Verification
On every cycle, the assertions check the following:
- the idle-high line;
- the start bit at the rise of busy;
- line and busy stability between baud ticks;
- no launch while disabled;
- the tx pin held high in loopback;
- the reserved bits reading as zero;
- the FIFO fill bound;
- the stickiness of overflow.

Only the bench's scenarios can show the rest, because the bench's reference model predicts the exact bit values. That includes LSB-first data order, FIFO ordering across an overflow, a frame completing after a mid-character disable, and a flush emptying queued bytes.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;
   localparam int          REG_W       = 32;
   localparam int          BIT_ENABLE  = 0;
   localparam int          BIT_LOOP    = 7;
   localparam int          BIT_TXEN    = 8;
   localparam int          BIT_RXEN    = 9;
   localparam logic [31:0] CTL_WMASK   = 32'h0000_CFBF;
   localparam logic [31:0] CTL_RESET   = 32'h0000_0300;

   typedef enum logic {SER_IDLE, SER_SEND} ser_state_e;
endpackage

// File: rtl/uart_ctl_reg.sv
module uart_ctl_reg
   import uart_ctl_pkg::*;
#(
   parameter int                ADDR_W = 12,
   parameter logic [ADDR_W-1:0] OFFSET = 12'h030
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   output logic [REG_W-1:0]  ctl_q
);
   logic hit_wr;

   assign hit_wr = wr_en && (wr_addr == OFFSET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_q <= CTL_RESET;
      else if (hit_wr)
         ctl_q <= wr_data & CTL_WMASK;
   end

   assign rd_data = (rd_addr == OFFSET) ? ctl_q : '0;
endmodule

// File: rtl/uart_txq.sv
module uart_txq #(
   parameter int W     = 8,
   parameter int DEPTH = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [W-1:0]     push_data,
   input  logic             pop,
   output logic [W-1:0]     head,
   output logic             empty,
   output logic             overflow,
   output logic [CNT_W-1:0] count
);
   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp, rp;
   logic             full, do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign head    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push)
         mem[wp] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp       <= '0;
         rp       <= '0;
         count    <= '0;
         overflow <= 1'b0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
         if (push && full)
            overflow <= 1'b1;
      end
   end
endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser
   import uart_ctl_pkg::*;
#(
   parameter int  W       = 8,
   localparam int FRAME   = W + 2,
   localparam int IDX_W   = $clog2(FRAME)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         go_ok,
   input  logic         avail,
   input  logic [W-1:0] data,
   output logic         pop,
   output logic         busy,
   output logic         line
);
   ser_state_e         state;
   logic [FRAME-1:0]   shreg;
   logic [IDX_W-1:0]   idx;
   logic               launch;

   assign launch = (state == SER_IDLE) && tick && go_ok && avail;
   assign pop    = launch;
   assign busy   = (state == SER_SEND);
   assign line   = busy ? shreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SER_IDLE;
         shreg <= '1;
         idx   <= '0;
      end else if (launch) begin
         state <= SER_SEND;
         shreg <= {1'b1, data, 1'b0};
         idx   <= '0;
      end else if (busy && tick) begin
         if (idx == IDX_W'(FRAME - 1)) begin
            state <= SER_IDLE;
         end else begin
            shreg <= {1'b1, shreg[FRAME-1:1]};
            idx   <= idx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/uart_ctl_tx.sv
module uart_ctl_tx
   import uart_ctl_pkg::*;
#(
   parameter int                ADDR_W       = 12,
   parameter logic [ADDR_W-1:0] CTL_OFFSET   = 12'h030,
   parameter int                CHAR_W       = 8,
   parameter int                FIFO_DEPTH   = 8,
   parameter bit                HAS_LOOPBACK = 1'b1,
   localparam int               CNT_W        = $clog2(FIFO_DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   input  logic              fifo_en,
   input  logic              push,
   input  logic [CHAR_W-1:0] push_data,
   input  logic              baud_tick,
   output logic              tx_pin,
   output logic              lb_out,
   output logic              busy,
   output logic              overflow,
   output logic              rx_gate
);
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two of at least 2");
   end
   if (CHAR_W < 5 || CHAR_W > 9) begin : g_bad_char
      $error("CHAR_W must lie between 5 and 9");
   end

   logic [31:0]       ctl_q;
   logic [CHAR_W-1:0] q_head;
   logic              q_empty, q_pop, ser_line;
   logic [CNT_W-1:0]  q_count;

   uart_ctl_reg #(.ADDR_W(ADDR_W), .OFFSET(CTL_OFFSET)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ctl_q(ctl_q)
   );

   uart_txq #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(!fifo_en), .push(push),
      .push_data(push_data), .pop(q_pop), .head(q_head), .empty(q_empty),
      .overflow(overflow), .count(q_count)
   );

   uart_tx_ser #(.W(CHAR_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick),
      .go_ok(ctl_q[BIT_ENABLE] && ctl_q[BIT_TXEN]), .avail(!q_empty),
      .data(q_head), .pop(q_pop), .busy(busy), .line(ser_line)
   );

   assign rx_gate = ctl_q[BIT_ENABLE] && ctl_q[BIT_RXEN];

   if (HAS_LOOPBACK) begin : g_loop
      assign tx_pin = ctl_q[BIT_LOOP] ? 1'b1 : ser_line;
      assign lb_out = ctl_q[BIT_LOOP] ? ser_line : 1'b1;
   end else begin : g_noloop
      assign tx_pin = ser_line;
      assign lb_out = 1'b1;
   end
endmodule

// File: rtl/uart_ctl_tx_chk.sv
module uart_ctl_tx_chk #(
   parameter int  DEPTH = 8,
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [31:0]      ctl,
   input logic             busy,
   input logic             line,
   input logic             tx_pin,
   input logic             lb_out,
   input logic             tick,
   input logic             overflow,
   input logic [CNT_W-1:0] count
);
   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl & ~32'h0000_CFBF) == 32'h0);

   assert_no_launch_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(ctl[0] && ctl[8])) |=> !busy);

   assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (tx_pin && lb_out));

   assert_start_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !line);

   assert_line_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> $stable(line));

   assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> busy);

   assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   assert_loop_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ctl[7] |-> tx_pin);
endmodule

bind uart_ctl_tx uart_ctl_tx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl(ctl_q), .busy(busy), .line(ser_line),
   .tx_pin(tx_pin), .lb_out(lb_out), .tick(baud_tick),
   .overflow(overflow), .count(q_count)
);

// File: tb/tb_uart_ctl_tx.sv
module tb_uart_ctl_tx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = 12'h030;
   logic [31:0] wr_data = '0;
   logic [11:0] rd_addr = 12'h030;
   logic [31:0] rd_data;
   logic        fifo_en = 1'b1;
   logic        push = 1'b0;
   logic [7:0]  push_data = '0;
   logic        baud_tick = 1'b0;
   logic        tx_pin, lb_out, busy, overflow, rx_gate;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   uart_ctl_tx dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .fifo_en(fifo_en), .push(push), .push_data(push_data),
      .baud_tick(baud_tick), .tx_pin(tx_pin), .lb_out(lb_out),
      .busy(busy), .overflow(overflow), .rx_gate(rx_gate)
   );

   // baud strobe: one cycle in four
   initial begin
      int div = 0;
      forever begin
         @(posedge clk); #1;
         baud_tick = (div == 3);
         div = (div + 1) % 4;
      end
   end

   // behavioural reference
   logic [31:0] m_ctl;
   byte unsigned q[$];
   logic        m_busy, m_ovf;
   logic [9:0]  m_frame;
   int          m_idx;

   always @(posedge clk) begin
      logic launch, full;
      byte unsigned b;
      if (!rst_n) begin
         m_ctl = 32'h300; q.delete(); m_busy = 0; m_ovf = 0; m_idx = 0; m_frame = '1;
      end else begin
         launch = !m_busy && baud_tick && m_ctl[0] && m_ctl[8] && (q.size() > 0);
         b = launch ? q[0] : 8'h00;
         full = (q.size() == 8);
         if (!fifo_en) q.delete();
         else begin
            if (launch) void'(q.pop_front());
            if (push) begin
               if (!full) q.push_back(push_data);
               else m_ovf = 1;
            end
         end
         if (m_busy && baud_tick) begin
            if (m_idx == 9) m_busy = 0;
            else m_idx++;
         end
         if (launch) begin
            m_busy = 1; m_frame = {1'b1, b, 1'b0}; m_idx = 0;
         end
         if (wr_en && wr_addr == 12'h030) m_ctl = wr_data & 32'h0000_CFBF;
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      logic el;
      if (rst_n) begin
         el = m_busy ? m_frame[m_idx] : 1'b1;
         check("R4 R9 tx_pin",   32'(tx_pin),   32'(m_ctl[7] ? 1'b1 : el));
         check("R9 lb_out",      32'(lb_out),   32'(m_ctl[7] ? el : 1'b1));
         check("R5 busy",        32'(busy),     32'(m_busy));
         check("R7 overflow",    32'(overflow), 32'(m_ovf));
         check("R10 rx_gate",    32'(rx_gate),  32'(m_ctl[0] && m_ctl[9]));
         check("R2 rd_data",     rd_data,       (rd_addr == 12'h030) ? m_ctl : 32'h0);
      end
   end

   task automatic cyc(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic wr(logic [31:0] d);
      @(posedge clk); #1; wr_en = 1; wr_data = d;
      @(posedge clk); #1; wr_en = 0;
   endtask

   task automatic push_b(byte unsigned d);
      @(posedge clk); #1; push = 1; push_data = d;
      @(posedge clk); #1; push = 0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while ((busy || q.size() > 0) && n < 3000) begin cyc(1); n++; end
      cyc(8);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      cyc(150000);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      cyc(3); rst_n = 1; cyc(1);
      // R1: reset value and foreign offset
      @(negedge clk); check("R1 reset value", rd_data, 32'h300);
      @(posedge clk); #1; rd_addr = 12'h034;
      @(negedge clk); check("R1 other offset", rd_data, 32'h0);
      @(posedge clk); #1; rd_addr = 12'h030;
      // R2: reserved bits stay zero
      wr(32'hFFFF_FFFF);
      @(negedge clk); check("R2 mask", rd_data, 32'h0000_CFBF);
      wr(32'h0000_0300);
      // R3: queued data waits while module disabled
      push_b(8'hA5); push_b(8'h3C);
      cyc(40);
      @(negedge clk); check("R3 held off", 32'(busy), 32'h0);
      wr(32'h0000_0001);
      cyc(40);
      @(negedge clk); check("R3 txe off held", 32'(busy), 32'h0);
      // R4 R5: frames go out once both enables set
      wr(32'h0000_0301);
      wait_idle();
      // R9: loopback routing
      wr(32'h0000_0381);
      push_b(8'h81); push_b(8'h7E);
      wait_idle();
      wr(32'h0000_0301);
      // R6: disable mid-frame
      push_b(8'hC3); push_b(8'h55);
      while (!busy) cyc(1);
      cyc(6);
      wr(32'h0000_0300);
      @(negedge clk); check("R6 frame continues", 32'(busy), 32'h1);
      cyc(60);
      @(negedge clk); check("R6 stopped after frame", 32'(busy), 32'h0);
      cyc(40);
      @(negedge clk); check("R6 no relaunch", 32'(busy), 32'h0);
      wr(32'h0000_0301);
      wait_idle();
      // R6: clear transmit enable mid-frame
      push_b(8'h0F); push_b(8'hF0);
      while (!busy) cyc(1);
      cyc(5);
      wr(32'h0000_0201);
      cyc(70);
      @(negedge clk); check("R6 txe cleared stops", 32'(busy), 32'h0);
      check("R10 rx_gate on", 32'(rx_gate), 32'h1);
      wr(32'h0000_0301);
      wait_idle();
      // R7: overflow and order
      wr(32'h0000_0300);
      for (int i = 0; i < 10; i++) push_b(byte'(8'h10 + i));
      @(negedge clk); check("R7 overflow set", 32'(overflow), 32'h1);
      wr(32'h0000_0301);
      wait_idle();
      // R8: flush discards queued bytes
      wr(32'h0000_0300);
      push_b(8'h99); push_b(8'h66);
      @(posedge clk); #1; fifo_en = 0; push = 1; push_data = 8'h44;
      @(posedge clk); #1; fifo_en = 1; push = 0;
      wr(32'h0000_0301);
      cyc(60);
      @(negedge clk); check("R8 flushed", 32'(busy), 32'h0);
      check("R7 overflow sticky", 32'(overflow), 32'h1);
      // R10: receive gate
      wr(32'h0000_0001);
      @(negedge clk); check("R10 rx_gate off", 32'(rx_gate), 32'h0);
      cyc(4);
      finish_run();
   end
endmodule